// File: doc/BRIEF.md
# Function Readiness Message Queue

This block sits beside a root port or an event collector and keeps the readiness notifications that arrive from downstream functions. A decoder upstream presents one message event per cycle. Each event carries a two-bit kind code, a function identifier and a reason code. Function-ready events are stored in a first-in first-out queue whose depth is a parameter, which may be set anywhere from 1 to 4095 entries. Software removes entries through a pop strobe. It can either poll the entry count or enable a level interrupt that stays high while entries are waiting.

The block also follows device-ready events seen on the attached downstream port. Such an event sets a sticky received flag, which is reflected in a two-bit presence status. When conversion is enabled, the event also produces a one-cycle forwarded ready notification or a one-cycle interrupt pulse, as the conversion mode selects. Event kinds the block does not know are dropped silently.

Top module: `ready_msg_queue`

## Requirements
- R1: The event kind is encoded as follows: 2'b01 means function ready, 2'b10 means device ready, and 2'b00 and 2'b11 are unrecognised. A function-ready event that finds the queue not full stores {function id, reason}, and `q_count` is one higher after that clock edge.
- R2: A pop strobe on a non-empty queue makes `pop_valid` high in the following cycle. In that same cycle it presents the oldest stored entry on `pop_func_id` and `pop_reason` and lowers `q_count` by one. Entries leave in arrival order.
- R3: A pop strobe on an empty queue gives `pop_valid` = 0 in the following cycle and leaves `q_count` at 0.
- R4: A function-ready event that finds the queue full is discarded, `q_count` stays at DEPTH, and the sticky `q_overflow` bit is set. `ovf_clr` = 1 clears the bit. When an overflow and `ovf_clr` happen in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when `irq_en` = 1 and `q_count` is not 0. It falls in the cycle after the last entry is popped.
- R6: An event with an unrecognised kind changes no queue state, no sticky bit and no pulse output.
- R7: A device-ready event sets the sticky `dev_rcvd` bit from the next cycle on, and it does not touch the queue. `dev_rcvd_clr` = 1 clears the bit, and a new device-ready event in the same cycle wins over the clear.
- R8: `dev_presence` is 2'b00 while `port_present` = 0. With a component present, it is 2'b01 while `dev_rcvd` = 0 and 2'b11 while `dev_rcvd` = 1.
- R9: With `conv_en` = 1, a device-ready event produces a one-cycle pulse in the next cycle. The pulse appears on `fwd_ready` when `conv_irq_mode` = 0 and on `dev_int` when `conv_irq_mode` = 1. With `conv_en` = 0 neither output pulses, and the two never pulse together.
- R10: When a push and a pop fall in the same cycle on a queue that is neither empty nor full, `q_count` does not change. On a full queue the push is still discarded and flagged as an overflow, even though the pop frees a slot in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | A decoded message event is present |
| evt_kind | input | 2 | Event kind code (01 function ready, 10 device ready) |
| evt_func_id | input | FID_W | Identifier of the function that sent the message |
| evt_reason | input | RSN_W | Reason code carried in the message |
| pop_req | input | 1 | Pop strobe from the register interface |
| ovf_clr | input | 1 | Write-1 clear of the overflow bit |
| irq_en | input | 1 | Queue interrupt enable |
| port_present | input | 1 | A downstream component is attached |
| dev_rcvd_clr | input | 1 | Write-1 clear of the device-ready received bit |
| conv_en | input | 1 | Turn device-ready events into a notification or an interrupt |
| conv_irq_mode | input | 1 | 0: forwarded notification, 1: interrupt pulse |
| pop_valid | output | 1 | Popped entry is valid |
| pop_func_id | output | FID_W | Function identifier of the popped entry |
| pop_reason | output | RSN_W | Reason code of the popped entry |
| q_count | output | CW | Number of queued entries |
| q_overflow | output | 1 | Sticky overflow status |
| irq | output | 1 | Level interrupt for a non-empty queue |
| dev_rcvd | output | 1 | Sticky device-ready received status |
| dev_presence | output | 2 | Downstream presence status |
| fwd_ready | output | 1 | One-cycle forwarded ready notification |
| dev_int | output | 1 | One-cycle device-ready interrupt pulse |

## Verification
The bench fills the queue to its limit and pushes once more, both alone and together with a pop. A design that let the concurrent pop make room would accept the extra entry and leave the overflow bit clear. It also pops an empty queue and pops the last entry. A wrong design would show a stale valid entry, let the count wrap below zero, or keep the interrupt up after the queue has drained. Unrecognised kinds, conversion with the enable off, and a set that coincides with a clear are all driven to catch a design that reacts where it must stay quiet. Such a design would write a queue entry, pulse the wrong output, or let the clear win.

// File: rtl/rmq_pkg.sv
// Shared types for the function readiness message queue.
// Assumes the decoder upstream already maps message codes onto msg_kind_e.
package rmq_pkg;
    parameter int FID_W = 16;
    parameter int RSN_W = 4;

    typedef enum logic [1:0] {
        MSG_NONE       = 2'b00,
        MSG_FUNC_READY = 2'b01,
        MSG_DEV_READY  = 2'b10,
        MSG_RSVD       = 2'b11
    } msg_kind_e;

    typedef struct packed {
        logic [FID_W-1:0] func_id;
        logic [RSN_W-1:0] reason;
    } rdy_entry_t;
endpackage

// File: rtl/rmq_decode.sv
// Classifies an incoming event by its kind code.
// Assumes at most one event per cycle; unknown kinds assert no output.
module rmq_decode
    import rmq_pkg::*;
(
    input  logic       evt_valid,
    input  logic [1:0] evt_kind,
    output logic       is_func,
    output logic       is_dev
);
    msg_kind_e kind;

    // Map the raw code onto the enumerated kind and qualify with valid.
    always_comb begin
        kind    = msg_kind_e'(evt_kind);
        is_func = evt_valid && (kind == MSG_FUNC_READY);
        is_dev  = evt_valid && (kind == MSG_DEV_READY);
    end
endmodule

// File: rtl/rmq_store.sv
// Circular entry store with occupancy count.
// Assumes the caller discards pushes while full; a pop in the same cycle
// does not make room for a push (full is judged on the current count).
module rmq_store
    import rmq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rdy_entry_t    wdata,
    input  logic          pop,
    output rdy_entry_t    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    rdy_entry_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept flags from current occupancy.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R1
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/rmq_dev_track.sv
// Tracks device-ready events on the downstream port: sticky flag,
// presence status and optional conversion into a notification or interrupt.
// Assumes dev_evt is a single-cycle qualified strobe.
module rmq_dev_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_evt,
    input  logic       clr,
    input  logic       port_present,
    input  logic       conv_en,
    input  logic       conv_irq_mode,
    output logic       rcvd,
    output logic [1:0] presence,
    output logic       fwd_pulse,
    output logic       int_pulse
);
    // Sticky received bit; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rcvd <= 1'b0;
        else if (dev_evt) rcvd <= 1'b1;
        else if (clr)     rcvd <= 1'b0;
    end

    // One-cycle conversion pulses steered by the mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_pulse <= 1'b0;
            int_pulse <= 1'b0;
        end else begin
            fwd_pulse <= dev_evt && conv_en && !conv_irq_mode;
            int_pulse <= dev_evt && conv_en &&  conv_irq_mode;
        end
    end

    // Presence status: absent, present, or present with ready seen.
    always_comb begin
        if (!port_present) presence = 2'b00;
        else if (rcvd)     presence = 2'b11;
        else               presence = 2'b01;
    end

    // R9
    conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_pulse, int_pulse}));
    // R7
    rcvd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_evt |=> rcvd);
    // R9
    conv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_evt && !conv_en) |=> !(fwd_pulse || int_pulse));
endmodule

// File: rtl/ready_msg_queue.sv
// Function readiness message queue: stores function-ready entries,
// serves them through a registered pop interface, raises a level interrupt
// while non-empty, flags overflow, and tracks device-ready events.
// Assumes one event per cycle and DEPTH within 1..4095.
module ready_msg_queue
    import rmq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [1:0]       evt_kind,
    input  logic [FID_W-1:0] evt_func_id,
    input  logic [RSN_W-1:0] evt_reason,
    input  logic             pop_req,
    input  logic             ovf_clr,
    input  logic             irq_en,
    input  logic             port_present,
    input  logic             dev_rcvd_clr,
    input  logic             conv_en,
    input  logic             conv_irq_mode,
    output logic             pop_valid,
    output logic [FID_W-1:0] pop_func_id,
    output logic [RSN_W-1:0] pop_reason,
    output logic [CW-1:0]    q_count,
    output logic             q_overflow,
    output logic             irq,
    output logic             dev_rcvd,
    output logic [1:0]       dev_presence,
    output logic             fwd_ready,
    output logic             dev_int
);
    generate
        if (DEPTH < 1 || DEPTH > 4095) begin : g_bad_depth
            $error("DEPTH out of range 1..4095");
        end
    endgenerate

    logic       is_func, is_dev, full, empty;
    rdy_entry_t wdata, head;

    rmq_decode u_dec (
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .is_func   (is_func),
        .is_dev    (is_dev)
    );

    // Pack the incoming entry fields.
    always_comb begin
        wdata.func_id = evt_func_id;
        wdata.reason  = evt_reason;
    end

    rmq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (is_func),
        .wdata (wdata),
        .pop   (pop_req),
        .head  (head),
        .count (q_count),
        .full  (full),
        .empty (empty)
    );

    // Registered pop response: valid only when an entry was there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid   <= 1'b0;
            pop_func_id <= '0;
            pop_reason  <= '0;
        end else begin
            pop_valid <= pop_req && !empty;
            if (pop_req && !empty) begin
                pop_func_id <= head.func_id;
                pop_reason  <= head.reason;
            end
        end
    end

    // Sticky overflow; a new overflow wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                q_overflow <= 1'b0;
        else if (is_func && full)  q_overflow <= 1'b1;
        else if (ovf_clr)          q_overflow <= 1'b0;
    end

    // Level interrupt from occupancy.
    always_comb irq = irq_en && !empty;

    rmq_dev_track u_dev (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_evt       (is_dev),
        .clr           (dev_rcvd_clr),
        .port_present  (port_present),
        .conv_en       (conv_en),
        .conv_irq_mode (conv_irq_mode),
        .rcvd          (dev_rcvd),
        .presence      (dev_presence),
        .fwd_pulse     (fwd_ready),
        .int_pulse     (dev_int)
    );

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_func && full) |=> q_overflow);
    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(1) && pop_req && !is_func) |=> !irq);
    // R6
    unknown_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_kind == 2'b00 || evt_kind == 2'b11) && !pop_req)
        |=> $stable(q_count));
    // R2
    pop_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q_count != '0) |=> pop_valid);
endmodule

// File: tb/ready_msg_queue_bench.sv
`timescale 1ns/1ps
module ready_msg_queue_bench;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int FW    = rmq_pkg::FID_W;
    localparam int RW    = rmq_pkg::RSN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 0, pop_req = 0, ovf_clr = 0, irq_en = 0;
    logic port_present = 0, dev_rcvd_clr = 0, conv_en = 0, conv_irq_mode = 0;
    logic [1:0] evt_kind = 0;
    logic [FW-1:0] evt_func_id = 0;
    logic [RW-1:0] evt_reason = 0;
    logic pop_valid, q_overflow, irq, dev_rcvd, fwd_ready, dev_int;
    logic [FW-1:0] pop_func_id;
    logic [RW-1:0] pop_reason;
    logic [CW-1:0] q_count;
    logic [1:0] dev_presence;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    bit done = 0;
    logic [FW+RW-1:0] exp_q[$];

    always #2 clk = ~clk;

    ready_msg_queue #(.DEPTH(DEPTH)) u_ready_msg_queue (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_func_id(evt_func_id), .evt_reason(evt_reason), .pop_req(pop_req),
        .ovf_clr(ovf_clr), .irq_en(irq_en), .port_present(port_present),
        .dev_rcvd_clr(dev_rcvd_clr), .conv_en(conv_en), .conv_irq_mode(conv_irq_mode),
        .pop_valid(pop_valid), .pop_func_id(pop_func_id), .pop_reason(pop_reason),
        .q_count(q_count), .q_overflow(q_overflow), .irq(irq), .dev_rcvd(dev_rcvd),
        .dev_presence(dev_presence), .fwd_ready(fwd_ready), .dev_int(dev_int)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare every popped entry against the scoreboard (R2).
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected pop", 1, 0);
            else begin
                logic [FW+RW-1:0] e;
                e = exp_q.pop_front();
                chk({pop_func_id, pop_reason} == e, "R2 entry order",
                    int'({pop_func_id, pop_reason}), int'(e));
            end
        end
    end

    // Driver: one cycle with an optional event and an optional pop.
    task automatic step(input logic [1:0] kind, input bit ev, input int id,
                        input int rsn, input bit pop);
        bit acc_push, acc_pop;
        acc_push = ev && kind == 2'b01 && mcount < DEPTH;
        acc_pop  = pop && mcount > 0;
        if (acc_push) exp_q.push_back({FW'(id), RW'(rsn)});
        evt_valid = ev; evt_kind = kind; evt_func_id = FW'(id);
        evt_reason = RW'(rsn); pop_req = pop;
        @(negedge clk);
        evt_valid = 0; evt_kind = 0; pop_req = 0;
        mcount = mcount + int'(acc_push) - int'(acc_pop);
        if (pop) chk(pop_valid == acc_pop, acc_pop ? "R2 pop_valid" : "R3 pop_valid",
                     int'(pop_valid), int'(acc_pop));
        chk(int'(q_count) == mcount, "R1/R10 q_count", int'(q_count), mcount);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(q_count == 0, "R1 reset count", int'(q_count), 0);
        chk(!q_overflow && !irq && !dev_rcvd && !pop_valid, "R4 reset flags",
            int'({q_overflow, irq, dev_rcvd, pop_valid}), 0);
        chk(dev_presence == 2'b00, "R8 absent", int'(dev_presence), 0);

        // R1/R5: two pushes, interrupt level
        irq_en = 1;
        step(2'b01, 1, 16'h0101, 3, 0);
        step(2'b01, 1, 16'h0a20, 7, 0);
        chk(irq == 1, "R5 irq nonempty", int'(irq), 1);
        irq_en = 0; #0;
        chk(irq == 0, "R5 irq disabled", int'(irq), 0);
        irq_en = 1;
        // R2: drain in order, R5: irq falls after last pop
        step(2'b00, 0, 0, 0, 1);
        chk(irq == 1, "R5 irq one left", int'(irq), 1);
        step(2'b00, 0, 0, 0, 1);
        chk(irq == 0, "R5 irq after last pop", int'(irq), 0);
        // R3: pop on empty
        step(2'b00, 0, 0, 0, 1);
        chk(q_count == 0, "R3 count stays", int'(q_count), 0);

        // R6: unrecognised kinds ignored
        conv_en = 1;
        step(2'b00, 1, 16'h1111, 1, 0);
        step(2'b11, 1, 16'h2222, 2, 0);
        chk(!dev_rcvd && !fwd_ready && !dev_int && !q_overflow, "R6 no side effect",
            int'({dev_rcvd, fwd_ready, dev_int, q_overflow}), 0);
        conv_en = 0;

        // R4: fill and overflow
        for (int i = 0; i < DEPTH; i++) step(2'b01, 1, 16'h3000 + i, i, 0);
        chk(q_overflow == 0, "R4 no overflow at full", int'(q_overflow), 0);
        step(2'b01, 1, 16'hdead, 15, 0);
        chk(q_overflow == 1, "R4 overflow set", int'(q_overflow), 1);
        ovf_clr = 1; step(2'b00, 0, 0, 0, 0); ovf_clr = 0;
        chk(q_overflow == 0, "R4 overflow cleared", int'(q_overflow), 0);
        ovf_clr = 1; step(2'b01, 1, 16'hbeef, 14, 0); ovf_clr = 0;
        chk(q_overflow == 1, "R4 set wins over clear", int'(q_overflow), 1);
        ovf_clr = 1; step(2'b00, 0, 0, 0, 0); ovf_clr = 0;

        // R10: full with push and pop together discards the push
        step(2'b01, 1, 16'hcafe, 9, 1);
        chk(q_overflow == 1, "R10 full push+pop overflow", int'(q_overflow), 1);
        chk(q_count == CW'(DEPTH - 1), "R10 full push+pop count", int'(q_count), DEPTH - 1);
        step(2'b01, 1, 16'h4444, 4, 1);
        chk(q_count == CW'(DEPTH - 1), "R10 mid push+pop count", int'(q_count), DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) step(2'b00, 0, 0, 0, 1);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        // R8/R7: presence and received flag
        port_present = 1; #0;
        chk(dev_presence == 2'b01, "R8 present no ready", int'(dev_presence), 1);
        step(2'b10, 1, 16'h0000, 0, 0);
        chk(dev_rcvd == 1, "R7 rcvd set", int'(dev_rcvd), 1);
        chk(dev_presence == 2'b11, "R8 present ready", int'(dev_presence), 3);
        chk(!fwd_ready && !dev_int, "R9 no pulse when off", int'({fwd_ready, dev_int}), 0);
        chk(q_count == 0, "R7 queue untouched", int'(q_count), 0);
        dev_rcvd_clr = 1; step(2'b10, 1, 0, 0, 0);
        chk(dev_rcvd == 1, "R7 event wins over clear", int'(dev_rcvd), 1);
        step(2'b00, 0, 0, 0, 0); dev_rcvd_clr = 0;
        chk(dev_rcvd == 0, "R7 rcvd cleared", int'(dev_rcvd), 0);

        // R9: conversion modes
        conv_en = 1; conv_irq_mode = 0;
        step(2'b10, 1, 0, 0, 0);
        chk(fwd_ready == 1 && dev_int == 0, "R9 forward pulse",
            int'({fwd_ready, dev_int}), 2);
        step(2'b00, 0, 0, 0, 0);
        chk(fwd_ready == 0, "R9 forward one cycle", int'(fwd_ready), 0);
        conv_irq_mode = 1;
        step(2'b10, 1, 0, 0, 0);
        chk(fwd_ready == 0 && dev_int == 1, "R9 interrupt pulse",
            int'({fwd_ready, dev_int}), 1);
        step(2'b00, 0, 0, 0, 0);
        chk(dev_int == 0, "R9 interrupt one cycle", int'(dev_int), 0);
        port_present = 0; #0;
        chk(dev_presence == 2'b00, "R8 absent again", int'(dev_presence), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule